// File: doc/BRIEF.md
# Glitch-Free Gain Code Latch Sequencer

This block sits between a host that asks for an amplifier gain and the switches that set it. The gain is a small binary word. A multi-bit code cannot change all its bits at the same instant, so it passes through unrelated codes on its way to a new value. The block keeps those passing codes away from the switches. It registers each new request and walks a staging register toward the new code, one bit per cycle. It then waits a programmable number of quiet cycles and opens an output latch for a short, fixed strobe. The switches therefore see the old code and then the new one, with nothing in between.

The output latch is modelled inside the block as a register that loads the staged bits on every cycle the strobe is high and holds them otherwise. A request that arrives before the strobe cancels the pending strobe, and the sequence starts again toward the newest value. A busy flag tells the host when a sequence is running.

Top module: `gain_latch_seq`

## Requirements
- R1: The gain word is GW = 4 bits, the plain binary value of the gain in dB (7 dB = 4'b0111, 8 dB = 4'b1000). `req_gain` is registered only in cycles where `req_valid` is 1. With `req_valid` at 0 the input has no effect.
- R2: While `latch_en` is 0, `gain_out` keeps its value from one clock edge to the next.
- R3: At every clock edge where `latch_en` was 1 before the edge, `gain_out` takes the value `stage_bits` had before that edge.
- R4: When the registered request differs from `gain_out`, the block drives `stage_bits` to the requested code and then strobes. When the sequence ends, `gain_out` equals the request.
- R5: `stage_bits` changes by at most one bit per clock, and it flips the lowest differing bit first. A move from a to b therefore takes exactly popcount(a xor b) bit changes. No intermediate code reaches `gain_out`.
- R6: `latch_en` rises only after `stage_bits` has stayed unchanged for at least `settle_len` cycles. A value of 0 acts as 1. Any change to the staged bits restarts this wait.
- R7: A new request that arrives while the bits are staging or settling cancels the pending strobe. The block restarts toward the newest value, and the superseded code never appears on `gain_out`.
- R8: Each strobe holds `latch_en` at 1 for exactly STROBE_LEN consecutive cycles (default 2). `stage_bits` does not change during the strobe.
- R9: After reset, `stage_bits` and `gain_out` are 4'b0000 and `latch_en` and `busy` are 0. The block stays idle while the request equals `gain_out`, so a request for the value already latched produces no strobe.
- R10: `busy` goes to 1 one cycle after a differing request is seen. It stays at 1 through the strobe and returns to 0 on the same edge where `latch_en` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Qualifies `req_gain` in this cycle |
| req_gain | input | GW | Requested binary gain code |
| settle_len | input | CW | Quiet cycles required before the strobe |
| stage_bits | output | GW | Staging register, moving one bit at a time |
| latch_en | output | 1 | Latch-enable strobe, resting low |
| gain_out | output | GW | Output latch driving the gain switches |
| busy | output | 1 | A sequence is in progress |

## Verification
Every cycle, the assertions check the following properties:
- the latch holds while closed and follows the staged bits while open;
- the staged code moves by at most one bit per cycle;
- the quiet period before each strobe is at least `settle_len`;
- the strobe width is exact;
- `busy` covers the strobe.

Some behaviours need the bench scenarios rather than the assertions:
- the output reaches the requested value;
- the bit walk takes popcount(a xor b) steps;
- a superseded request never reaches the output;
- a repeated or unqualified request does nothing.

The bench shows these by comparing against a record of the requests it issued.

// File: rtl/gain_latch_seq.sv
module gain_latch_seq #(
  parameter int GW = 4,
  parameter int CW = 8,
  parameter int STROBE_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [GW-1:0] req_gain,
  input  logic [CW-1:0] settle_len,
  output logic [GW-1:0] stage_bits,
  output logic          latch_en,
  output logic [GW-1:0] gain_out,
  output logic          busy
);
  localparam int SW = (STROBE_LEN < 2) ? 1 : $clog2(STROBE_LEN);

  typedef enum logic [1:0] {S_IDLE, S_STAGE, S_SETTLE, S_STROBE} state_t;

  state_t        state;
  logic [GW-1:0] req_q, tgt, stage, gain_q;
  logic [CW-1:0] wait_cnt;
  logic [SW-1:0] str_cnt;

  logic [GW-1:0] diff, low_bit;
  logic          renew, settled;

  assign diff    = stage ^ tgt;
  assign low_bit = diff & (~diff + {{(GW-1){1'b0}}, 1'b1});
  assign renew   = req_q != tgt;
  assign settled = ({1'b0, wait_cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, settle_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      req_q    <= '0;
      tgt      <= '0;
      stage    <= '0;
      gain_q   <= '0;
      wait_cnt <= '0;
      str_cnt  <= '0;
    end else begin
      if (req_valid) req_q <= req_gain;
      if (state == S_STROBE) gain_q <= stage;
      case (state)
        S_IDLE: begin
          if (req_q != gain_q) begin
            tgt   <= req_q;
            state <= S_STAGE;
          end
        end
        S_STAGE: begin
          if (renew) begin
            tgt <= req_q;
          end else if (diff != '0) begin
            stage <= stage ^ low_bit;
          end else begin
            wait_cnt <= '0;
            state    <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (renew) begin
            tgt   <= req_q;
            state <= S_STAGE;
          end else if (settled) begin
            str_cnt <= '0;
            state   <= S_STROBE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: begin
          if (str_cnt == SW'(STROBE_LEN - 1)) state <= S_IDLE;
          else str_cnt <= str_cnt + 1'b1;
        end
      endcase
    end
  end

  assign stage_bits = stage;
  assign gain_out   = gain_q;
  assign latch_en   = state == S_STROBE;
  assign busy       = state != S_IDLE;
endmodule

// File: rtl/gain_latch_seq_chk.sv
module gain_latch_seq_chk #(
  parameter int GW = 4,
  parameter int CW = 8,
  parameter int STROBE_LEN = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] settle_len,
  input logic [GW-1:0] stage_bits,
  input logic          latch_en,
  input logic [GW-1:0] gain_out,
  input logic          busy
);
  localparam int HW = $clog2(STROBE_LEN + 2) + 1;

  logic [GW-1:0] prev_stage;
  logic [CW:0]   quiet_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_stage <= '0;
      quiet_cnt  <= '0;
      hi_cnt     <= '0;
    end else begin
      prev_stage <= stage_bits;
      if (stage_bits != prev_stage) quiet_cnt <= '0;
      else if (quiet_cnt != '1) quiet_cnt <= quiet_cnt + 1'b1;
      if (latch_en) hi_cnt <= hi_cnt + 1'b1;
      else hi_cnt <= '0;
    end
  end

  a_r2_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> gain_out == $past(gain_out));

  a_r3_follow_open: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> gain_out == $past(stage_bits));

  a_r5_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(stage_bits ^ $past(stage_bits)) <= 1);

  a_r6_quiet_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_en) |-> quiet_cnt >= {1'b0, settle_len});

  a_r8_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_en) |-> hi_cnt == HW'(STROBE_LEN));

  a_r8_stage_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> stage_bits == $past(stage_bits));

  a_r10_busy_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> busy);
endmodule

bind gain_latch_seq gain_latch_seq_chk #(.GW(GW), .CW(CW), .STROBE_LEN(STROBE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .settle_len(settle_len), .stage_bits(stage_bits),
  .latch_en(latch_en), .gain_out(gain_out), .busy(busy)
);

// File: tb/gain_latch_seq_bench.sv
`timescale 1ns/1ps
module gain_latch_seq_bench;
  localparam int GW = 4;
  localparam int CW = 8;
  localparam int STROBE_LEN = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [GW-1:0] req_gain = '0;
  logic [CW-1:0] settle_len = 8'd20;
  logic [GW-1:0] stage_bits, gain_out;
  logic          latch_en, busy;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, mon_on = 0;

  logic [15:0]   mask = 16'h0001;
  logic [GW-1:0] last_req = '0;
  logic [15:0]   seen = '0;
  int            flip_cnt = 0, strobe_cnt = 0;

  gain_latch_seq #(.GW(GW), .CW(CW), .STROBE_LEN(STROBE_LEN)) u_gain_latch_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_gain(req_gain),
    .settle_len(settle_len), .stage_bits(stage_bits), .latch_en(latch_en),
    .gain_out(gain_out), .busy(busy)
  );

  always #4 clk = ~clk;

  function automatic int exp_flips(input logic [GW-1:0] a, input logic [GW-1:0] b);
    return $countones(a ^ b);
  endfunction

  function automatic int eff_settle(input logic [CW-1:0] s);
    return (s == 0) ? 1 : int'(s);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  task automatic request(input logic [GW-1:0] v);
    @(negedge clk);
    req_valid = 1'b1;
    req_gain  = v;
    mask[v]   = 1'b1;
    last_req  = v;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  logic [GW-1:0] p_stage, p_gain;
  logic          p_le;
  int            quiet, hi_run;

  always @(posedge clk) begin
    cyc++;
    #1;
    if (mon_on) begin
      chk(p_le || gain_out == p_gain, "R2 hold while closed", gain_out, p_gain);
      if (p_le) chk(gain_out == p_stage, "R3 follow while open", gain_out, p_stage);
      chk(exp_flips(stage_bits, p_stage) <= 1, "R5 one bit per cycle",
          exp_flips(stage_bits, p_stage), 1);
      if (stage_bits != p_stage) begin
        flip_cnt++;
        quiet = 0;
      end else quiet++;
      if (latch_en && !p_le) begin
        strobe_cnt++;
        chk(quiet >= eff_settle(settle_len), "R6 quiet before strobe", quiet, eff_settle(settle_len));
      end
      if (latch_en) begin
        chk(busy, "R10 busy during strobe", busy, 1);
        chk(p_le == 0 || stage_bits == p_stage, "R8 stage frozen", stage_bits, p_stage);
        hi_run++;
      end else begin
        if (p_le) chk(hi_run == STROBE_LEN, "R8 strobe width", hi_run, STROBE_LEN);
        hi_run = 0;
      end
      if (gain_out != p_gain) begin
        chk(mask[gain_out], "R7 only requested codes latched", gain_out, last_req);
        seen[gain_out] = 1'b1;
        mask = '0;
        mask[last_req] = 1'b1;
      end
    end
    p_stage = stage_bits;
    p_gain  = gain_out;
    p_le    = latch_en;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    p_stage = '0; p_gain = '0; p_le = 1'b0; quiet = 100; hi_run = 0;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    chk(stage_bits == 0, "R9 reset stage", stage_bits, 0);
    chk(gain_out == 0, "R9 reset gain_out", gain_out, 0);
    chk(!latch_en && !busy, "R9 reset strobe and busy", {latch_en, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;

    // R1: unqualified input ignored
    req_gain = 4'd9;
    repeat (10) @(negedge clk);
    chk(!busy, "R1 no valid no busy", busy, 0);
    chk(gain_out == 0, "R1 no valid no change", gain_out, 0);

    // R9: request equal to latched value gives no strobe
    strobe_cnt = 0;
    request(4'd0);
    repeat (30) @(negedge clk);
    chk(strobe_cnt == 0 && !busy, "R9 equal request idle", strobe_cnt, 0);

    // R4 R5 R10: 0 -> 7 -> 8
    flip_cnt = 0; strobe_cnt = 0;
    request(4'd7);
    @(negedge clk);
    chk(busy, "R10 busy after change", busy, 1);
    wait_idle();
    chk(gain_out == 7, "R4 reach 7", gain_out, 7);
    chk(flip_cnt == exp_flips(4'd0, 4'd7), "R5 flips 0->7", flip_cnt, exp_flips(4'd0, 4'd7));
    chk(strobe_cnt == 1, "R8 one strobe per change", strobe_cnt, 1);
    flip_cnt = 0;
    request(4'd8);
    wait_idle();
    chk(gain_out == 8, "R4 reach 8", gain_out, 8);
    chk(flip_cnt == exp_flips(4'd7, 4'd8), "R5 flips 7->8", flip_cnt, exp_flips(4'd7, 4'd8));

    // R7: supersede during settle
    seen = '0; strobe_cnt = 0;
    request(4'd3);
    repeat (8) @(negedge clk);
    request(4'd12);
    wait_idle();
    chk(gain_out == 12, "R7 newest value latched", gain_out, 12);
    chk(seen[3] == 0, "R7 superseded code never latched", seen[3], 0);
    chk(strobe_cnt == 1, "R7 pending strobe aborted", strobe_cnt, 1);

    // R6 corner: settle_len 0 and 1
    settle_len = 8'd0;
    request(4'd5);
    wait_idle();
    chk(gain_out == 5, "R6 settle 0 acts as 1", gain_out, 5);
    settle_len = 8'd1;
    request(4'd15);
    wait_idle();
    chk(gain_out == 15, "R6 settle 1", gain_out, 15);

    // random phase
    settle_len = 8'd6;
    for (int it = 0; it < 300; it++) begin
      request(4'($urandom_range(0, 15)));
      if ($urandom_range(0, 3) == 0) begin
        wait_idle();
        chk(gain_out == last_req, "R4 random settle", gain_out, last_req);
      end else begin
        repeat ($urandom_range(0, 25)) @(negedge clk);
      end
    end
    wait_idle();
    chk(gain_out == last_req, "R4 final value", gain_out, last_req);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule